// File: doc/BRIEF.md
# Byte Serial Port with Select-Gated Output Enable

This block is a byte-wide synchronous serial port. It works either as the clock-driving master or as a follower clocked from outside. A 4-bit mode code picks the role and, for the master, the bit-clock source. Software drives it through a small register port. A write to the data register loads a byte into the transmit shifter. A received byte lands in a holding buffer, and a full flag marks it. The serial clock idles low. Two configuration bits choose the launch edge and, for the master, how late input data is sampled.

In the follower mode that watches the select line, a high select discards any partial byte and withdraws the peripheral output enable, which tri-states the data-out pin. The pin-direction bit that software reads back is the stored direction bit ORed with the inverted peripheral enable. A read-modify-write of that bit while the port is deselected therefore stores "input", and the data-out pin stays off after reselection until software clears the bit.

The register port has no handshake and never stalls. A data write that arrives while a byte is moving is dropped and reported through a write-collision flag. A completed byte that finds the buffer still unread is dropped and reported through an overflow flag. Register map (reg_addr): 0 control, 1 status, 2 data, 3 direction.

Top module: `spi_port`

## Requirements
- R1: Control register (address 0) holds mode in bits 3:0, enable in bit 4, CKE in bit 5 and SMP in bit 6. With enable set, modes 0, 1 and 2 make a master whose sck_out rising edges are 4, 16 and 64 clk cycles apart. Mode 3 toggles sck_out once per tmr_match pulse, so a full clock period spans two pulses.
- R2: A master transfer starts on a data-register write (address 2). It drives 8 sck_out pulses with sck_out idle low and sends the written byte MSB first on sdo. The byte sampled from sdi, MSB first, goes to the buffer and buf_full rises.
- R3: With CKE=0 the first bit appears on sdo when the byte is loaded, later bits change on falling sck and input is sampled on rising sck. With CKE=1 bits are launched on rising sck and sampled on falling sck.
- R4: In master mode SMP=1 moves each input sample one half-period later, to the end of its bit time.
- R5: Mode 5 is a follower clocked by sck_in and exchanges bytes with ss_n ignored.
- R6: In mode 4 a high ss_n clears the bit counter and the partial byte, so the next full byte after ss_n returns low is received intact.
- R7: sdo_oe is high in master mode, in mode 4 only while ss_n is low, and in mode 5 with CKE=0. In every case it also needs the stored direction bit to be 0.
- R8: Reading address 3 returns in bit 0 the stored direction bit ORed with the inverted peripheral enable. Writing bit 0 stores it. Writing back a value read while ss_n is high keeps sdo_oe low after ss_n falls.
- R9: Mode 5 with CKE=1 is unsupported and holds sdo_oe low.
- R10: Reading the data register returns the buffered byte and clears buf_full (status bit 0).
- R11: A data write while a transfer is in progress is ignored and sets status bit 1 (write collision). Writing 1 to that bit clears it.
- R12: A byte that completes while buf_full is set is dropped, the buffer keeps its old byte, and status bit 2 (overflow) is set. It clears when 1 is written to it.
- R13: After reset the port is disabled, buf_full, sdo_oe and sck_oe are low, the control register reads 0 and the direction bit reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Instruction clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (read side effects) |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr |
| tmr_match | input | 1 | Timer-match pulse used as master clock source |
| sck_in | input | 1 | Serial clock from an external master |
| sck_out | output | 1 | Serial clock driven in master mode |
| sck_oe | output | 1 | Drive enable for sck_out |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Output enable to the data-out pin logic |
| ss_n | input | 1 | Slave select, active low |
| buf_full | output | 1 | Receive buffer holds an unread byte |

## Verification
On every cycle, assertions check that a high select in mode 4 empties the bit counter on the next cycle. They also check that a data write during a transfer raises the collision flag, that a byte landing on a full buffer raises overflow and leaves the buffer unchanged, and that the master clock changes only on its ticks and rests low after the last one. Only the bench scenarios can show the byte values exchanged under each edge and sample setting, the clock periods of each source, and the read-modify-write sequence on the direction bit. The same holds for the output-enable outcome of each mode.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;
  typedef enum logic [1:0] {
    A_CTRL = 2'd0,
    A_STAT = 2'd1,
    A_DATA = 2'd2,
    A_DIR  = 2'd3
  } reg_addr_e;

  localparam logic [3:0] MODE_SEL  = 4'd4;
  localparam logic [3:0] MODE_FREE = 4'd5;

  typedef struct packed {
    logic       smp;
    logic       cke;
    logic       en;
    logic [3:0] mode;
  } ctrl_t;
endpackage

// File: rtl/spi_port_clkgen.sv
module spi_port_clkgen #(
  parameter int unsigned NUM_BITS   = 8,
  parameter int unsigned HALF_DIV4  = 2,
  parameter int unsigned HALF_DIV16 = 8,
  parameter int unsigned HALF_DIV64 = 32,
  localparam int unsigned TICKS = 2 * NUM_BITS,
  localparam int unsigned TW    = $clog2(TICKS + 2),
  localparam int unsigned CW    = $clog2(HALF_DIV64 + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          abort_i,
  input  logic [1:0]    src_i,
  input  logic          tmr_match_i,
  input  logic          long_i,
  output logic          sck_o,
  output logic          busy_o,
  output logic          tick_o,
  output logic [TW-1:0] tick_idx_o,
  output logic          done_o
);
  logic [CW-1:0] pcnt, half_m1;
  logic [TW-1:0] tnum, last;

  always_comb begin
    case (src_i)
      2'd0:    half_m1 = CW'(HALF_DIV4 - 1);
      2'd1:    half_m1 = CW'(HALF_DIV16 - 1);
      2'd2:    half_m1 = CW'(HALF_DIV64 - 1);
      default: half_m1 = '0;
    endcase
  end

  assign tick_o     = busy_o && ((src_i == 2'd3) ? tmr_match_i : (pcnt == half_m1));
  assign tick_idx_o = tnum + 1'b1;
  assign last       = TW'(TICKS) + TW'(long_i);
  assign done_o     = tick_o && (tick_idx_o == last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_o <= 1'b0;
      sck_o  <= 1'b0;
      pcnt   <= '0;
      tnum   <= '0;
    end else if (abort_i) begin
      busy_o <= 1'b0;
      sck_o  <= 1'b0;
      pcnt   <= '0;
      tnum   <= '0;
    end else if (start_i) begin
      busy_o <= 1'b1;
      sck_o  <= 1'b0;
      pcnt   <= '0;
      tnum   <= '0;
    end else if (busy_o) begin
      if (tick_o) begin
        pcnt <= '0;
        tnum <= tick_idx_o;
        if (tick_idx_o <= TW'(TICKS)) sck_o <= ~sck_o;
        if (done_o) busy_o <= 1'b0;
      end else begin
        pcnt <= pcnt + 1'b1;
      end
    end
  end

  assert_sck_on_tick_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_o && !abort_i && !start_i) |=> $stable(sck_o));

  assert_sck_idle_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !abort_i) |=> !sck_o);
endmodule

// File: rtl/spi_port_shifter.sv
module spi_port_shifter #(
  parameter int unsigned W = 8,
  localparam int unsigned CW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear_i,
  input  logic          load_i,
  input  logic [W-1:0]  load_d_i,
  input  logic          preload_i,
  input  logic          launch_i,
  input  logic          capture_i,
  input  logic          sdi_i,
  output logic          sdo_o,
  output logic [CW-1:0] bit_cnt_o,
  output logic          done_o,
  output logic [W-1:0]  word_o
);
  logic [W-1:0] tx_sr, rx_sr;

  assign done_o = capture_i && !clear_i && (bit_cnt_o == CW'(W - 1));
  assign word_o = {rx_sr[W-2:0], sdi_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt_o <= '0;
      rx_sr     <= '0;
    end else if (clear_i) begin
      bit_cnt_o <= '0;
      rx_sr     <= '0;
    end else if (capture_i) begin
      rx_sr     <= word_o;
      bit_cnt_o <= done_o ? '0 : bit_cnt_o + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sr <= '0;
      sdo_o <= 1'b0;
    end else if (load_i) begin
      if (preload_i) begin
        sdo_o <= load_d_i[W-1];
        tx_sr <= {load_d_i[W-2:0], 1'b0};
      end else begin
        tx_sr <= load_d_i;
      end
    end else if (launch_i) begin
      sdo_o <= tx_sr[W-1];
      tx_sr <= {tx_sr[W-2:0], 1'b0};
    end
  end
endmodule

// File: rtl/spi_port.sv
module spi_port #(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned HALF_DIV4   = 2,
  parameter int unsigned HALF_DIV16  = 8,
  parameter int unsigned HALF_DIV64  = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [1:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       tmr_match,
  input  logic       sck_in,
  output logic       sck_out,
  output logic       sck_oe,
  input  logic       sdi,
  output logic       sdo,
  output logic       sdo_oe,
  input  logic       ss_n,
  output logic       buf_full
);
  import spi_port_pkg::*;

  localparam int unsigned TW = $clog2(2 * DATA_W + 2);
  localparam int unsigned BW = $clog2(DATA_W);

  ctrl_t             ctrl;
  logic              dir_q, wcol_q, ovf_q;
  logic [DATA_W-1:0] rbuf;
  logic [SYNC_STAGES-1:0] sck_p, sdi_p, ss_p;
  logic              sck_d, sck_s, sdi_s, ss_s;

  // input synchronisers for the follower path
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_p <= '0;
      sdi_p <= '0;
      ss_p  <= '1;
      sck_d <= 1'b0;
    end else begin
      sck_p <= {sck_p[SYNC_STAGES-2:0], sck_in};
      sdi_p <= {sdi_p[SYNC_STAGES-2:0], sdi};
      ss_p  <= {ss_p[SYNC_STAGES-2:0], ss_n};
      sck_d <= sck_s;
    end
  end
  assign sck_s = sck_p[SYNC_STAGES-1];
  assign sdi_s = sdi_p[SYNC_STAGES-1];
  assign ss_s  = ss_p[SYNC_STAGES-1];

  // mode decode
  logic is_master, is_sel, is_free, is_slave, ss_reset, periph_oe;
  assign is_master = ctrl.en && (ctrl.mode[3:2] == 2'b00);
  assign is_sel    = ctrl.en && (ctrl.mode == MODE_SEL);
  assign is_free   = ctrl.en && (ctrl.mode == MODE_FREE);
  assign is_slave  = is_sel || is_free;
  assign ss_reset  = is_sel && ss_s;
  assign periph_oe = is_master || (is_sel && !ss_s) || (is_free && !ctrl.cke);
  assign sdo_oe    = periph_oe && !dir_q;
  assign sck_oe    = is_master;

  // register strobes
  logic wr_ctrl, wr_stat, wr_data, wr_dir, rd_data;
  assign wr_ctrl = reg_wr && (reg_addr_e'(reg_addr) == A_CTRL);
  assign wr_stat = reg_wr && (reg_addr_e'(reg_addr) == A_STAT);
  assign wr_data = reg_wr && (reg_addr_e'(reg_addr) == A_DATA);
  assign wr_dir  = reg_wr && (reg_addr_e'(reg_addr) == A_DIR);
  assign rd_data = reg_rd && (reg_addr_e'(reg_addr) == A_DATA);

  // master clock generator
  logic          cg_busy, cg_tick, cg_done, start;
  logic [TW-1:0] cg_idx;
  spi_port_clkgen #(
    .NUM_BITS(DATA_W), .HALF_DIV4(HALF_DIV4),
    .HALF_DIV16(HALF_DIV16), .HALF_DIV64(HALF_DIV64)
  ) u_clkgen (
    .clk(clk), .rst_n(rst_n), .start_i(start),
    .abort_i(wr_ctrl || !is_master), .src_i(ctrl.mode[1:0]),
    .tmr_match_i(tmr_match), .long_i(ctrl.cke && ctrl.smp),
    .sck_o(sck_out), .busy_o(cg_busy), .tick_o(cg_tick),
    .tick_idx_o(cg_idx), .done_o(cg_done)
  );

  // edge selection: odd ticks are rising edges of sck_out
  logic odd, m_cap, m_launch, sl_rise, sl_fall, sl_cap, sl_launch;
  assign odd = cg_idx[0];
  assign m_cap = cg_tick && (ctrl.smp ? (ctrl.cke ? (odd && cg_idx >= TW'(3)) : !odd)
                                      : (ctrl.cke ? !odd : odd));
  assign m_launch = cg_tick && (ctrl.cke ? (odd && cg_idx <= TW'(2 * DATA_W - 1))
                                         : (!odd && cg_idx <= TW'(2 * DATA_W - 2)));
  assign sl_rise   = sck_s && !sck_d;
  assign sl_fall   = !sck_s && sck_d;
  assign sl_cap    = is_slave && !ss_reset && (ctrl.cke ? sl_fall : sl_rise);
  assign sl_launch = is_slave && !ss_reset && (ctrl.cke ? sl_rise : sl_fall);

  // shifter
  logic              busy, load, byte_done;
  logic [BW-1:0]     bit_cnt;
  logic [DATA_W-1:0] word;
  assign busy  = is_master ? cg_busy : (bit_cnt != '0);
  assign load  = wr_data && !busy && (is_master || is_slave);
  assign start = load && is_master;

  spi_port_shifter #(.W(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_n),
    .clear_i(wr_ctrl || !(is_master || is_slave) || ss_reset),
    .load_i(load), .load_d_i(reg_wdata[DATA_W-1:0]), .preload_i(!ctrl.cke),
    .launch_i(is_master ? m_launch : sl_launch),
    .capture_i(is_master ? m_cap : sl_cap),
    .sdi_i(is_master ? sdi : sdi_s),
    .sdo_o(sdo), .bit_cnt_o(bit_cnt), .done_o(byte_done), .word_o(word)
  );

  // registers and flags
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl     <= '0;
      dir_q    <= 1'b1;
      rbuf     <= '0;
      buf_full <= 1'b0;
      wcol_q   <= 1'b0;
      ovf_q    <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl <= ctrl_t'(reg_wdata[6:0]);
      if (wr_dir)  dir_q <= reg_wdata[0];
      if (byte_done) begin
        if (buf_full && !rd_data) begin
          ovf_q <= 1'b1;
        end else begin
          rbuf     <= word;
          buf_full <= 1'b1;
        end
      end else if (rd_data) begin
        buf_full <= 1'b0;
      end
      if (wr_data && busy)              wcol_q <= 1'b1;
      else if (wr_stat && reg_wdata[1]) wcol_q <= 1'b0;
      if (wr_stat && reg_wdata[2] && !(byte_done && buf_full && !rd_data)) ovf_q <= 1'b0;
    end
  end

  always_comb begin
    case (reg_addr_e'(reg_addr))
      A_CTRL:  reg_rdata = {1'b0, ctrl};
      A_STAT:  reg_rdata = {5'b0, ovf_q, wcol_q, buf_full};
      A_DATA:  reg_rdata = 8'(rbuf);
      default: reg_rdata = {7'b0, dir_q || !periph_oe};
    endcase
  end

  assert_ss_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ss_reset |=> (bit_cnt == '0));

  assert_write_collision_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_data && busy) |=> wcol_q);

  assert_no_overflow_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && buf_full && !rd_data) |=> (ovf_q && $stable(rbuf)));
endmodule

// File: tb/test_spi_port.sv
module test_spi_port;
  localparam int CLK_HALF = 10;
  localparam int H = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       tmr_match = 1'b0;
  logic       sck_in = 1'b0, sdi = 1'b0, ss_n = 1'b1;
  logic       sck_out, sck_oe, sdo, sdo_oe, buf_full;
  logic       tmr_on = 1'b0;
  int         tmr_cnt = 0;
  int         n_chk = 0, n_err = 0;

  always #(CLK_HALF) clk = ~clk;

  spi_port i_spi_port (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .tmr_match(tmr_match), .sck_in(sck_in), .sck_out(sck_out), .sck_oe(sck_oe),
    .sdi(sdi), .sdo(sdo), .sdo_oe(sdo_oe), .ss_n(ss_n), .buf_full(buf_full)
  );

  always @(posedge clk) begin
    if (tmr_on) begin
      tmr_cnt   <= (tmr_cnt == 4) ? 0 : tmr_cnt + 1;
      tmr_match <= (tmr_cnt == 4);
    end else begin
      tmr_match <= 1'b0;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // external follower model driven by sck_out
  task automatic follower(input logic cke, input logic late, input logic [7:0] rx,
                          output logic [7:0] got, output int per);
    time t1, t2;
    t1 = 0; t2 = 0;
    if (!cke && !late) sdi = rx[7];
    for (int i = 7; i >= 0; i--) begin
      @(posedge sck_out);
      if (i == 7) t1 = $time;
      if (i == 6) t2 = $time;
      if (!cke) begin
        if (late) sdi = rx[i];
        got[i] = sdo;
        @(negedge sck_out);
        if (!late && i > 0) sdi = rx[i-1];
      end else begin
        if (!late) sdi = rx[i];
        @(negedge sck_out);
        got[i] = sdo;
        if (late) sdi = rx[i];
      end
    end
    per = int'((t2 - t1) / (2 * CLK_HALF));
  endtask

  task automatic run_master(input logic [3:0] mode, input logic cke, input logic smp,
                            input logic [7:0] tx, input logic [7:0] rx, input int exp_per,
                            input logic rd_after, input logic collide, input string req);
    logic [7:0] got, d;
    int per;
    reg_write(2'd0, {1'b0, smp, cke, 1'b1, mode});
    reg_write(2'd3, 8'h00);
    chk({req, " master sdo_oe"}, sdo_oe, 1'b1);
    fork
      follower(cke, smp, rx, got, per);
      begin
        reg_write(2'd2, tx);
        if (collide) begin
          idle(5);
          reg_write(2'd2, ~tx);
        end
      end
    join
    idle(80);
    chk({req, " byte sent on sdo"}, got, tx);
    chk({req, " sck period"}, per, exp_per);
    if (rd_after) begin
      chk({req, " R10 buf_full set"}, buf_full, 1'b1);
      reg_read(2'd2, d);
      chk({req, " byte received"}, d, rx);
      chk({req, " R10 buf_full cleared"}, buf_full, 1'b0);
    end
  endtask

  // bench acts as master towards the port in follower mode
  task automatic drive_bits(input logic cke, input logic [7:0] mosi, input int nbits,
                            output logic [7:0] miso);
    miso = '0;
    for (int i = 7; i > 7 - nbits; i--) begin
      if (!cke) begin
        sdi = mosi[i]; idle(H);
        sck_in = 1'b1; miso[i] = sdo; idle(H);
        sck_in = 1'b0;
      end else begin
        sck_in = 1'b1; sdi = mosi[i]; idle(H);
        sck_in = 1'b0; miso[i] = sdo; idle(H);
      end
    end
    idle(6);
  endtask

  task automatic test_reset;
    logic [7:0] d;
    chk("R13 buf_full", buf_full, 1'b0);
    chk("R13 sdo_oe", sdo_oe, 1'b0);
    chk("R13 sck_oe", sck_oe, 1'b0);
    reg_read(2'd0, d); chk("R13 ctrl", d, 8'h00);
    reg_read(2'd3, d); chk("R13 dir", d, 8'h01);
  endtask

  task automatic test_master_modes;
    run_master(4'd0, 1'b0, 1'b0, 8'hA5, 8'h3C, 4,  1'b1, 1'b0, "R1 R2 R3 div4 cke0");
    run_master(4'd1, 1'b1, 1'b0, 8'h5A, 8'hC3, 16, 1'b1, 1'b0, "R1 R3 div16 cke1");
    run_master(4'd2, 1'b0, 1'b1, 8'h81, 8'h7E, 64, 1'b1, 1'b0, "R1 R4 div64 cke0 smp");
    run_master(4'd0, 1'b1, 1'b1, 8'h96, 8'h69, 4,  1'b1, 1'b0, "R4 div4 cke1 smp");
    tmr_on = 1'b1;
    run_master(4'd3, 1'b0, 1'b0, 8'hF0, 8'h0F, 10, 1'b1, 1'b0, "R1 timer");
    tmr_on = 1'b0;
    chk("R2 sck_out idle low", sck_out, 1'b0);
  endtask

  task automatic test_collision;
    logic [7:0] d;
    run_master(4'd0, 1'b0, 1'b0, 8'hA5, 8'h5C, 4, 1'b1, 1'b1, "R11 collision");
    reg_read(2'd1, d); chk("R11 wcol flag", d[1], 1'b1);
    reg_write(2'd1, 8'h02);
    reg_read(2'd1, d); chk("R11 wcol cleared", d[1], 1'b0);
  endtask

  task automatic test_overflow;
    logic [7:0] d;
    run_master(4'd0, 1'b0, 1'b0, 8'h11, 8'h22, 4, 1'b0, 1'b0, "R12 first");
    run_master(4'd0, 1'b0, 1'b0, 8'h44, 8'h33, 4, 1'b0, 1'b0, "R12 second");
    reg_read(2'd1, d); chk("R12 overflow flag", d[2], 1'b1);
    reg_read(2'd2, d); chk("R12 old byte kept", d, 8'h22);
    reg_write(2'd1, 8'h04);
    reg_read(2'd1, d); chk("R12 overflow cleared", d[2], 1'b0);
  endtask

  task automatic test_free_follower;
    logic [7:0] m, d;
    ss_n = 1'b1;
    reg_write(2'd0, 8'h15);
    reg_write(2'd3, 8'h00);
    chk("R7 mode5 cke0 sdo_oe", sdo_oe, 1'b1);
    reg_write(2'd2, 8'h96);
    drive_bits(1'b0, 8'h5A, 8, m);
    reg_read(2'd2, d);
    chk("R5 received with ss_n high", d, 8'h5A);
    chk("R5 R3 sent", m, 8'h96);
    reg_write(2'd0, 8'h35);
    idle(2);
    chk("R9 mode5 cke1 sdo_oe", sdo_oe, 1'b0);
  endtask

  task automatic test_select_follower;
    logic [7:0] m, d;
    ss_n = 1'b0;
    reg_write(2'd0, 8'h34);
    reg_write(2'd3, 8'h00);
    idle(4);
    reg_write(2'd2, 8'hC3);
    drive_bits(1'b1, 8'h3C, 8, m);
    reg_read(2'd2, d);
    chk("R3 cke1 received", d, 8'h3C);
    chk("R3 cke1 sent", m, 8'hC3);
    reg_write(2'd0, 8'h14);
    idle(4);
    chk("R7 selected sdo_oe", sdo_oe, 1'b1);
    drive_bits(1'b0, 8'hE0, 3, m);
    ss_n = 1'b1; idle(4);
    chk("R7 deselected sdo_oe", sdo_oe, 1'b0);
    reg_read(2'd3, d);
    chk("R8 dir reads 1 while deselected", d[0], 1'b1);
    reg_write(2'd3, d);
    ss_n = 1'b0; idle(4);
    chk("R8 sdo_oe stays low after rmw", sdo_oe, 1'b0);
    reg_write(2'd3, 8'h00);
    chk("R7 sdo_oe after dir cleared", sdo_oe, 1'b1);
    reg_write(2'd2, 8'h81);
    drive_bits(1'b0, 8'h4B, 8, m);
    reg_read(2'd2, d);
    chk("R6 byte after select reset", d, 8'h4B);
    chk("R6 sent after select reset", m, 8'h81);
  endtask

  task automatic finish_run;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(2);
    test_reset();
    test_master_modes();
    test_collision();
    test_overflow();
    test_free_follower();
    test_select_follower();
    finish_run();
  end
endmodule